// File: doc/BRIEF.md
# Event Timer Main Counter Register File

This block is the software-facing register file of a multi-channel event timer. It keeps the free-running 64-bit main counter, a read-only capability word, the global configuration, and one register window per channel. Each window holds a configuration word, a 64-bit comparator and a 64-bit route word. Software reaches all of them through a simple request interface that carries only 32-bit accesses. The counter advances by one on every cycle in which `tick` is high and the block is globally enabled.

The counter is governed by a two-state machine with states `CNT_HALT` and `CNT_RUN`. The transition named *start* goes from `CNT_HALT` to `CNT_RUN` and happens when a global configuration write sets the enable bit. The transition named *stop* goes from `CNT_RUN` to `CNT_HALT` and happens when such a write clears that bit. In `CNT_HALT` the counter holds its value. On *start*, the block emits a one-cycle re-arm pulse to each channel whose comparator is not all ones.

Channel timing and interrupt delivery sit in neighbouring blocks. This block feeds them the register contents, one-cycle write strobes and the status-clear request.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset the counter reads 0, the global configuration reads 0, and every channel comparator reads all ones. Every channel configuration low word reads 0x30 (bit 4 = periodic-capable, bit 5 = 64-bit-capable), and its high word reads the parameter ROUTE_CAP.
- R2: An access whose size (`req_size`, in bytes) is not 4, or whose address has nonzero bits [1:0], is dropped. Such a write changes nothing, and such a read returns 0.
- R3: The capability low word at offset 0x000 reads vendor[31:16], legacy-route support bit 15 = 1, 64-bit counter bit 13 = 1, NUM_CH-1 in bits [12:8], and revision in bits [7:0]. The word at 0x004 reads the tick period in femtoseconds. Writes to either word are ignored.
- R4: The global configuration sits at 0x010, with bit 0 = enable and bit 1 = legacy route; all other bits read 0. The word at 0x014 reads 0, and writes to it are ignored.
- R5: While enabled, the counter rises by exactly one on each cycle with `tick` high. Its halves read at 0x0F0 (low) and 0x0F4 (high), one cycle after the request.
- R6: Clearing the enable bit freezes the counter, whatever `tick` does. Setting it again resumes counting from the held value.
- R7: Each counter half can be written at any time, including while enabled. The written half takes the new value, overriding that cycle's increment, and the other half keeps its value.
- R8: On the cycle after a write that sets the enable bit from 0, `ch_rearm` pulses for exactly one cycle. The pulse has bit n set for each channel whose comparator is not all ones.
- R9: Channel n's window starts at 0x100 + 0x20*n. Within a window, the words are: configuration low +0x00, configuration high +0x04, comparator low +0x08, comparator high +0x0C, route low +0x10, route high +0x14.
- R10: A channel configuration low write updates only bits under mask 0x7F4E and keeps all other bits. The configuration high word is read-only.
- R11: A channel index at or beyond NUM_CH, or a window offset above +0x14, reads 0. Writes to either are dropped and raise no strobe.
- R12: The cycle after an accepted write to a writable channel word, `ch_wr_stb[n]` is high for one cycle and `ch_wr_word` gives the word code (address bits [4:2]: 0 config low, 2 comparator low, 3 comparator high, 4 route low, 5 route high).
- R13: Offset 0x020 reads `isr_in`. A write to it produces `isr_clr_stb` for one cycle, with `isr_clr_data` equal to the written data, on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance qualifier |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes, only 4 accepted |
| req_addr | input | 10 | Byte offset |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| counter | output | 64 | Main counter value |
| glb_enable | output | 1 | Global enable (counter state is run) |
| legacy_route | output | 1 | Legacy route bit |
| ch_cfg | output | NUM_CH*64 | Channel configuration words |
| ch_cmp | output | NUM_CH*64 | Channel comparators |
| ch_route | output | NUM_CH*64 | Channel route words |
| ch_wr_stb | output | NUM_CH | Per-channel write strobe |
| ch_wr_word | output | 3 | Word code of the strobed write |
| ch_rearm | output | NUM_CH | Re-arm pulse on start |
| isr_in | input | NUM_CH | Interrupt status from the interrupt block |
| isr_clr_stb | output | 1 | Status-clear request |
| isr_clr_data | output | 32 | Status-clear bit pattern |

## Verification
The hardest case to reach is a counter-half write that lands on the same edge as a live `tick` increment while the machine is in `CNT_RUN`. An increment that leaks through shows up only as an off-by-one. The bench raises `tick` in the very cycle it drives the write and drops it right after that edge. It then counts a known number of ticks across the low-to-high carry, so any leaked increment or broken carry changes the read-back value. The one-cycle re-arm pulse is checked on the exact cycle after *start* and again one cycle later. The channel comparators are set up beforehand so that the expected pulse has a mix of set and clear bits.

// File: rtl/evt_regs_pkg.sv
package evt_regs_pkg;

    localparam int          MAX_CH        = 24;
    localparam logic [2:0]  ACC_BYTES     = 3'd4;

    localparam logic [9:0]  OFS_CAP_LO    = 10'h000;
    localparam logic [9:0]  OFS_CAP_HI    = 10'h004;
    localparam logic [9:0]  OFS_GCFG_LO   = 10'h010;
    localparam logic [9:0]  OFS_GCFG_HI   = 10'h014;
    localparam logic [9:0]  OFS_STATUS    = 10'h020;
    localparam logic [9:0]  OFS_CNT_LO    = 10'h0F0;
    localparam logic [9:0]  OFS_CNT_HI    = 10'h0F4;
    localparam logic [4:0]  CHAN_FIRST_BLK = 5'd8;  // 0x100 >> 5

    localparam logic [31:0] GCFG_MASK     = 32'h0000_0003;
    localparam logic [31:0] CH_CFG_MASK   = 32'h0000_7F4E;
    localparam logic [31:0] CH_CAP_BITS   = 32'h0000_0030;

    typedef enum logic [3:0] {
        DK_NONE,
        DK_CAP_LO,
        DK_CAP_HI,
        DK_GCFG_LO,
        DK_GCFG_HI,
        DK_STATUS,
        DK_CNT_LO,
        DK_CNT_HI,
        DK_CHAN
    } dec_kind_e;

    typedef enum logic [2:0] {
        CW_CFG_LO = 3'd0,
        CW_CFG_HI = 3'd1,
        CW_CMP_LO = 3'd2,
        CW_CMP_HI = 3'd3,
        CW_RTE_LO = 3'd4,
        CW_RTE_HI = 3'd5,
        CW_RSV6   = 3'd6,
        CW_RSV7   = 3'd7
    } chan_word_e;

    typedef struct packed {
        dec_kind_e  kind;
        logic [4:0] ch;
        chan_word_e word;
    } dec_t;

    typedef enum logic {
        CNT_HALT = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
    import evt_regs_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [9:0] addr,
    input  logic [2:0] size,
    output dec_t       dec
);

    logic [4:0] blk_idx;

    always_comb begin
        blk_idx  = addr[9:5] - CHAN_FIRST_BLK;
        dec.kind = DK_NONE;
        dec.ch   = '0;
        dec.word = CW_CFG_LO;
        if (size == ACC_BYTES && addr[1:0] == 2'b00) begin
            if (addr[9:8] != 2'b00) begin
                if (int'(blk_idx) < NUM_CH && addr[4:2] <= 3'd5) begin
                    dec.kind = DK_CHAN;
                    dec.ch   = blk_idx;
                    dec.word = chan_word_e'(addr[4:2]);
                end
            end else begin
                case (addr)
                    OFS_CAP_LO:  dec.kind = DK_CAP_LO;
                    OFS_CAP_HI:  dec.kind = DK_CAP_HI;
                    OFS_GCFG_LO: dec.kind = DK_GCFG_LO;
                    OFS_GCFG_HI: dec.kind = DK_GCFG_HI;
                    OFS_STATUS:  dec.kind = DK_STATUS;
                    OFS_CNT_LO:  dec.kind = DK_CNT_LO;
                    OFS_CNT_HI:  dec.kind = DK_CNT_HI;
                    default:     dec.kind = DK_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_regs_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gcfg_wr,
    input  logic             cnt_wr_lo,
    input  logic             cnt_wr_hi,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] count_o,
    output logic             enable_o,
    output logic             legacy_o,
    output logic             run_start_o
);

    localparam int HALF_W = CNT_W / 2;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             legacy_q;
    logic             start_q;
    logic             inc;
    logic             start_d;

    // next-state logic: start / stop transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALT: if (gcfg_wr && wdata[0])  state_d = CNT_RUN;
            CNT_RUN:  if (gcfg_wr && !wdata[0]) state_d = CNT_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_HALT;
        else        state_q <= state_d;
    end

    // output decode from the state
    always_comb begin
        inc      = 1'b0;
        start_d  = 1'b0;
        enable_o = 1'b0;
        unique case (state_q)
            CNT_HALT: begin
                start_d = (state_d == CNT_RUN);
            end
            CNT_RUN: begin
                enable_o = 1'b1;
                inc      = tick;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            legacy_q <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            start_q <= start_d;
            if (gcfg_wr) legacy_q <= wdata[1];
            if (cnt_wr_lo)      count_q[HALF_W-1:0]     <= wdata[HALF_W-1:0];
            else if (cnt_wr_hi) count_q[CNT_W-1:HALF_W] <= wdata[HALF_W-1:0];
            else if (inc)       count_q <= count_q + 1'b1;
        end
    end

    assign count_o     = count_q;
    assign legacy_o    = legacy_q;
    assign run_start_o = start_q;

    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_HALT && !cnt_wr_lo && !cnt_wr_hi) |=> (count_q == $past(count_q)));

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && tick && !cnt_wr_lo && !cnt_wr_hi) |=> (count_q == $past(count_q) + 1'b1));

    a_r7_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_lo |=> (count_q[HALF_W-1:0] == $past(wdata[HALF_W-1:0]) &&
                       count_q[CNT_W-1:HALF_W] == $past(count_q[CNT_W-1:HALF_W])));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);

endmodule

// File: rtl/evt_chan_regs.sv
module evt_chan_regs
    import evt_regs_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAP = 32'h0000_0F04
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  chan_word_e  word,
    input  logic [31:0] wdata,
    output logic [63:0] cfg_o,
    output logic [63:0] cmp_o,
    output logic [63:0] route_o,
    output logic        stb_o
);

    logic [31:0] cfg_lo_q;
    logic [63:0] cmp_q;
    logic [63:0] rte_q;
    logic        stb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_lo_q <= CH_CAP_BITS;
            cmp_q    <= '1;
            rte_q    <= '0;
            stb_q    <= 1'b0;
        end else begin
            stb_q <= wr_en && (word != CW_CFG_HI);
            if (wr_en) begin
                case (word)
                    CW_CFG_LO: cfg_lo_q     <= (wdata & CH_CFG_MASK) | (cfg_lo_q & ~CH_CFG_MASK);
                    CW_CMP_LO: cmp_q[31:0]  <= wdata;
                    CW_CMP_HI: cmp_q[63:32] <= wdata;
                    CW_RTE_LO: rte_q[31:0]  <= wdata;
                    CW_RTE_HI: rte_q[63:32] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign cfg_o   = {ROUTE_CAP, cfg_lo_q};
    assign cmp_o   = cmp_q;
    assign route_o = rte_q;
    assign stb_o   = stb_q;

    a_r10_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == CW_CFG_LO) |=> ((cfg_lo_q & ~CH_CFG_MASK) == $past(cfg_lo_q & ~CH_CFG_MASK)));

    a_r10_hi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == CW_CFG_HI) |=> ($stable(cfg_lo_q) && $stable(cmp_q) && $stable(rte_q) && !stb_q));

    a_r12_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word != CW_CFG_HI) |=> stb_q);

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_regs_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter logic [7:0]  REVISION  = 8'h01,
    parameter logic [15:0] VENDOR    = 16'h1D0F,
    parameter logic [31:0] TICK_FS   = 32'd10_000_000,
    parameter logic [31:0] ROUTE_CAP = 32'h0000_0F04
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [2:0]           req_size,
    input  logic [9:0]           req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic [63:0]          counter,
    output logic                 glb_enable,
    output logic                 legacy_route,
    output logic [NUM_CH*64-1:0] ch_cfg,
    output logic [NUM_CH*64-1:0] ch_cmp,
    output logic [NUM_CH*64-1:0] ch_route,
    output logic [NUM_CH-1:0]    ch_wr_stb,
    output logic [2:0]           ch_wr_word,
    output logic [NUM_CH-1:0]    ch_rearm,
    input  logic [NUM_CH-1:0]    isr_in,
    output logic                 isr_clr_stb,
    output logic [31:0]          isr_clr_data
);

    localparam logic [4:0]  CH_FIELD = 5'(NUM_CH - 1);
    localparam logic [31:0] CAP_LO   = {VENDOR, 1'b1, 1'b0, 1'b1, CH_FIELD, REVISION};

    dec_t        dec;
    logic        wr_go;
    logic        run_start;
    logic [31:0] rd_mux;
    logic [31:0] rd_q;
    logic        rd_v_q;
    logic        isr_stb_q;
    logic [31:0] isr_data_q;
    logic [2:0]  word_q;
    logic [63:0] cfg_a   [NUM_CH];
    logic [63:0] cmp_a   [NUM_CH];
    logic [63:0] rte_a   [NUM_CH];
    logic [NUM_CH-1:0] armable;

    evt_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .dec  (dec)
    );

    assign wr_go = req_valid && req_write;

    evt_main_counter #(.CNT_W(64)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .gcfg_wr     (wr_go && dec.kind == DK_GCFG_LO),
        .cnt_wr_lo   (wr_go && dec.kind == DK_CNT_LO),
        .cnt_wr_hi   (wr_go && dec.kind == DK_CNT_HI),
        .wdata       (req_wdata),
        .count_o     (counter),
        .enable_o    (glb_enable),
        .legacy_o    (legacy_route),
        .run_start_o (run_start)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic ch_stb;
        evt_chan_regs #(.ROUTE_CAP(ROUTE_CAP)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_go && dec.kind == DK_CHAN && dec.ch == 5'(n)),
            .word    (dec.word),
            .wdata   (req_wdata),
            .cfg_o   (cfg_a[n]),
            .cmp_o   (cmp_a[n]),
            .route_o (rte_a[n]),
            .stb_o   (ch_stb)
        );
        assign ch_cfg[n*64 +: 64]   = cfg_a[n];
        assign ch_cmp[n*64 +: 64]   = cmp_a[n];
        assign ch_route[n*64 +: 64] = rte_a[n];
        assign ch_wr_stb[n]         = ch_stb;
        assign armable[n]           = ~&cmp_a[n];
    end

    assign ch_rearm = run_start ? armable : '0;

    always_comb begin
        rd_mux = '0;
        case (dec.kind)
            DK_CAP_LO:  rd_mux = CAP_LO;
            DK_CAP_HI:  rd_mux = TICK_FS;
            DK_GCFG_LO: rd_mux = {30'd0, legacy_route, glb_enable} & GCFG_MASK;
            DK_STATUS:  rd_mux = 32'(isr_in);
            DK_CNT_LO:  rd_mux = counter[31:0];
            DK_CNT_HI:  rd_mux = counter[63:32];
            DK_CHAN: begin
                for (int n = 0; n < NUM_CH; n++) begin
                    if (dec.ch == 5'(n)) begin
                        case (dec.word)
                            CW_CFG_LO: rd_mux = cfg_a[n][31:0];
                            CW_CFG_HI: rd_mux = cfg_a[n][63:32];
                            CW_CMP_LO: rd_mux = cmp_a[n][31:0];
                            CW_CMP_HI: rd_mux = cmp_a[n][63:32];
                            CW_RTE_LO: rd_mux = rte_a[n][31:0];
                            CW_RTE_HI: rd_mux = rte_a[n][63:32];
                            default:   rd_mux = '0;
                        endcase
                    end
                end
            end
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q       <= '0;
            rd_v_q     <= 1'b0;
            isr_stb_q  <= 1'b0;
            isr_data_q <= '0;
            word_q     <= '0;
        end else begin
            rd_v_q    <= req_valid && !req_write;
            rd_q      <= (req_valid && !req_write) ? rd_mux : '0;
            isr_stb_q <= wr_go && dec.kind == DK_STATUS;
            if (wr_go && dec.kind == DK_STATUS) isr_data_q <= req_wdata;
            if (wr_go && dec.kind == DK_CHAN)   word_q     <= dec.word;
        end
    end

    assign rd_valid     = rd_v_q;
    assign rd_data      = rd_q;
    assign isr_clr_stb  = isr_stb_q;
    assign isr_clr_data = isr_data_q;
    assign ch_wr_word   = word_q;

    a_r11_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_go && dec.kind == DK_CHAN) |=> (ch_wr_stb == '0));

    a_r8_rearm_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_rearm) |-> (glb_enable && !$past(glb_enable)));

    a_r13_clear_req: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && dec.kind == DK_STATUS) |=> (isr_clr_stb && isr_clr_data == $past(req_wdata)));

    a_r2_bad_size_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size != ACC_BYTES) |=> (rd_valid && rd_data == 32'd0));

endmodule

// File: tb/evt_timer_regs_test.sv
module evt_timer_regs_test;

    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [2:0]        req_size = 3'd4;
    logic [9:0]        req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic [63:0]       counter;
    logic              glb_enable;
    logic              legacy_route;
    logic [NCH*64-1:0] ch_cfg, ch_cmp, ch_route;
    logic [NCH-1:0]    ch_wr_stb, ch_rearm;
    logic [2:0]        ch_wr_word;
    logic [NCH-1:0]    isr_in = '0;
    logic              isr_clr_stb;
    logic [31:0]       isr_clr_data;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    evt_timer_regs #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .counter(counter), .glb_enable(glb_enable), .legacy_route(legacy_route),
        .ch_cfg(ch_cfg), .ch_cmp(ch_cmp), .ch_route(ch_route),
        .ch_wr_stb(ch_wr_stb), .ch_wr_word(ch_wr_word), .ch_rearm(ch_rearm),
        .isr_in(isr_in), .isr_clr_stb(isr_clr_stb), .isr_clr_data(isr_clr_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 20000)", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    // drives at a falling edge, returns at the next falling edge
    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d, input logic [2:0] sz = 3'd4);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_size = 3'd4;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d, input logic [2:0] sz = 3'd4);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        d = rd_data;
        req_valid = 1'b0; req_size = 3'd4;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 counter", counter, 64'd0);
        bus_rd(10'h010, v); chk("R1 gcfg", {32'd0, v}, 64'd0);
        bus_rd(10'h108, v); chk("R1 ch0 cmp lo", {32'd0, v}, 64'hFFFF_FFFF);
        bus_rd(10'h12C, v); chk("R1 ch1 cmp hi", {32'd0, v}, 64'hFFFF_FFFF);
        bus_rd(10'h140, v); chk("R1 ch2 cfg lo", {32'd0, v}, 64'h30);
        bus_rd(10'h144, v); chk("R1 ch2 cfg hi", {32'd0, v}, 64'h0F04);
    endtask

    task automatic t_capability();
        logic [31:0] v;
        bus_rd(10'h000, v); chk("R3 cap lo", {32'd0, v}, 64'h1D0F_A201);
        bus_rd(10'h004, v); chk("R3 cap hi", {32'd0, v}, 64'd10_000_000);
        bus_wr(10'h000, 32'h0);
        bus_wr(10'h004, 32'h1);
        bus_rd(10'h000, v); chk("R3 cap lo after write", {32'd0, v}, 64'h1D0F_A201);
        bus_rd(10'h004, v); chk("R3 cap hi after write", {32'd0, v}, 64'd10_000_000);
    endtask

    task automatic t_gcfg();
        logic [31:0] v;
        bus_wr(10'h010, 32'hFFFF_FFFC);
        bus_rd(10'h010, v); chk("R4 masked bits", {32'd0, v}, 64'd0);
        bus_wr(10'h010, 32'h0000_0002);
        bus_rd(10'h010, v); chk("R4 legacy bit", {32'd0, v}, 64'd2);
        chk("R4 legacy port", {63'd0, legacy_route}, 64'd1);
        bus_wr(10'h014, 32'hFFFF_FFFF);
        bus_rd(10'h014, v); chk("R4 upper half", {32'd0, v}, 64'd0);
        bus_wr(10'h010, 32'h0);
    endtask

    task automatic t_chan_window();
        logic [31:0] v;
        bus_wr(10'h148, 32'h1111_2222);
        bus_wr(10'h14C, 32'h3333_4444);
        bus_wr(10'h150, 32'h5555_6666);
        bus_wr(10'h154, 32'h7777_8888);
        bus_rd(10'h148, v); chk("R9 ch2 cmp lo", {32'd0, v}, 64'h1111_2222);
        bus_rd(10'h14C, v); chk("R9 ch2 cmp hi", {32'd0, v}, 64'h3333_4444);
        chk("R9 ch2 route port", ch_route[2*64 +: 64], 64'h7777_8888_5555_6666);
        chk("R9 ch0 cmp untouched", ch_cmp[0 +: 64], 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_chan_cfg_mask();
        logic [31:0] v;
        bus_wr(10'h120, 32'hFFFF_FFFF);
        bus_rd(10'h120, v); chk("R10 cfg all ones", {32'd0, v}, 64'h7F7E);
        bus_wr(10'h120, 32'h0);
        bus_rd(10'h120, v); chk("R10 cfg zeros keep caps", {32'd0, v}, 64'h30);
        bus_wr(10'h124, 32'h1234_5678);
        bus_rd(10'h124, v); chk("R10 cfg hi read-only", {32'd0, v}, 64'h0F04);
    endtask

    task automatic t_strobe();
        req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h12C; req_wdata = 32'hABCD_0000;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R12 stb ch1", {61'd0, ch_wr_stb}, 64'b010);
        chk("R12 word code", {61'd0, ch_wr_word}, 64'd3);
        @(negedge clk);
        chk("R12 stb one cycle", {61'd0, ch_wr_stb}, 64'd0);
        bus_wr(10'h12C, 32'hFFFF_FFFF);
        bus_wr(10'h104, 32'h5);
        chk("R12 no stb on cfg hi", {61'd0, ch_wr_stb}, 64'd0);
    endtask

    task automatic t_out_of_range();
        logic [31:0] v;
        bus_rd(10'h160, v); chk("R11 ch3 read", {32'd0, v}, 64'd0);
        bus_wr(10'h168, 32'h9);
        chk("R11 ch3 write no stb", {61'd0, ch_wr_stb}, 64'd0);
        bus_rd(10'h118, v); chk("R11 window gap read", {32'd0, v}, 64'd0);
        bus_wr(10'h118, 32'h9);
        chk("R11 gap write no stb", {61'd0, ch_wr_stb}, 64'd0);
        bus_rd(10'h030, v); chk("R11 unmapped global", {32'd0, v}, 64'd0);
        chk("R11 ch0 intact", ch_cmp[0 +: 64], 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_size();
        logic [31:0] v;
        bus_wr(10'h108, 32'h0000_0042, 3'd2);
        chk("R2 short write dropped", ch_cmp[0 +: 64], 64'hFFFF_FFFF_FFFF_FFFF);
        bus_wr(10'h109, 32'h0000_0042);
        chk("R2 misaligned write dropped", ch_cmp[0 +: 64], 64'hFFFF_FFFF_FFFF_FFFF);
        bus_rd(10'h000, v, 3'd8); chk("R2 wide read zero", {32'd0, v}, 64'd0);
        bus_rd(10'h001, v); chk("R2 misaligned read zero", {32'd0, v}, 64'd0);
    endtask

    task automatic t_rearm();
        bus_wr(10'h108, 32'h5);   // ch0 comparator no longer all ones
        bus_wr(10'h010, 32'h1);
        chk("R8 rearm mask", {61'd0, ch_rearm}, 64'b101);
        @(negedge clk);
        chk("R8 rearm one cycle", {61'd0, ch_rearm}, 64'd0);
        bus_wr(10'h010, 32'h0);
    endtask

    task automatic t_count_freeze();
        logic [31:0] v;
        bus_wr(10'h0F0, 32'h0);
        bus_wr(10'h0F4, 32'h0);
        bus_wr(10'h010, 32'h1);
        tick = 1'b1;
        repeat (10) @(negedge clk);
        tick = 1'b0;
        chk("R5 ten ticks", counter, 64'd10);
        bus_rd(10'h0F0, v); chk("R5 low read", {32'd0, v}, 64'd10);
        repeat (3) @(negedge clk);
        chk("R5 no tick no step", counter, 64'd10);
        bus_wr(10'h010, 32'h0);
        tick = 1'b1;
        repeat (5) @(negedge clk);
        tick = 1'b0;
        chk("R6 frozen", counter, 64'd10);
        bus_wr(10'h010, 32'h1);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        chk("R6 resumed", counter, 64'd13);
    endtask

    task automatic t_cnt_write_live();
        logic [31:0] v;
        tick = 1'b1;
        bus_wr(10'h0F0, 32'hFFFF_FFF0);
        tick = 1'b0;
        chk("R7 write wins", counter, 64'h0000_0000_FFFF_FFF0);
        tick = 1'b1;
        repeat (16) @(negedge clk);
        tick = 1'b0;
        bus_rd(10'h0F4, v); chk("R7 carry high", {32'd0, v}, 64'd1);
        bus_rd(10'h0F0, v); chk("R7 carry low", {32'd0, v}, 64'd0);
        bus_wr(10'h0F4, 32'h7);
        chk("R7 high write keeps low", counter, 64'h0000_0007_0000_0000);
        bus_wr(10'h010, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        isr_in = 3'b101;
        bus_rd(10'h020, v); chk("R13 status read", {32'd0, v}, 64'd5);
        bus_wr(10'h020, 32'h4);
        chk("R13 clear strobe", {63'd0, isr_clr_stb}, 64'd1);
        chk("R13 clear data", {32'd0, isr_clr_data}, 64'd4);
        @(negedge clk);
        chk("R13 strobe one cycle", {63'd0, isr_clr_stb}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capability();
        t_gcfg();
        t_chan_window();
        t_chan_cfg_mask();
        t_strobe();
        t_out_of_range();
        t_size();
        t_rearm();
        t_count_freeze();
        t_cnt_write_live();
        t_status();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule